// File: doc/BRIEF.md
# Uplink Download Handshake Controller

A mobile unit keeps its position records in an external byte memory and hands them to a base station over a byte-wide serial link. This controller runs that hand-over. It listens to the received byte stream for the base station's poll word `free`. It waits a per-unit priority delay so that units contend in order, and then sends its one-byte unit ID. It expects a one-byte acknowledge. When it gets one, it raises a stop line to the logging process. It then streams every stored byte, followed by the number of complete records it sent.

The base station answers with a mismatch byte or a success byte. A mismatch replays the whole memory from address 0. Success puts the controller into a power-off state, which it leaves only on the next ignition pulse. If no acknowledge arrives, the ID is sent a second time. A second silence sends the controller back to listening. The serial transmitter, the receiver and the memory are outside the block. Memory reads are combinational: data for `mem_addr_o` is expected in the same cycle.

Top module: `uplink_dl_ctrl`

## Requirements
- R1: After reset the controller listens for the poll word, `tx_valid_o`, `log_stop_o` and `power_off_o` are low, and `mem_addr_o` is 0.
- R2: Only the four consecutive valid received bytes 0x66, 0x72, 0x65, 0x65 ("free") start a contention. Any other byte sequence does not. A poll word preceded by a partial prefix (e.g. "ffree") is still recognised.
- R3: The ID byte (`unit_id_i`) becomes valid exactly `prio_delay_i`+2 cycles after the clock edge that accepts the final 0x65 of the poll word.
- R4: After the ID is accepted by the transmitter, the controller waits ACK_TO+1 cycles for the acknowledge byte 0x06. If none arrives, the ID is sent once more. After a second timeout the controller returns to listening without raising `log_stop_o`.
- R5: While waiting for acknowledge, bytes other than 0x06 are ignored. An acknowledge sampled in the same cycle as the timeout expiry is taken as an acknowledge. An acknowledge arriving while the retry ID is being sent is ignored.
- R6: `log_stop_o` rises on the edge that accepts the acknowledge and stays high through the whole download. No data byte is offered while it is low.
- R7: Data bytes are offered from address 0 up to `last_ptr_i` in order. Each byte and its address stay unchanged until `tx_ready_i` accepts it.
- R8: After the last data byte, the controller sends the number of complete REC_BYTES-sized records as two bytes, high byte first.
- R9: The mismatch byte 0x15 restarts the download from address 0, including the count bytes. Other response bytes are ignored.
- R10: The success byte 0x04 drives `power_off_o` high with the transmitter idle. Poll words are then ignored until a `wake_i` pulse, which clears `power_off_o` and `log_stop_o` and resumes listening.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wake_i | input | 1 | Ignition pulse, leaves power-off |
| unit_id_i | input | 8 | ID byte of this unit |
| prio_delay_i | input | DLY_W | Contention delay in cycles |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| tx_ready_i | input | 1 | Transmitter can take a byte |
| tx_valid_o | output | 1 | Byte offered to transmitter |
| tx_data_o | output | 8 | Offered byte |
| last_ptr_i | input | AW | Address of last stored byte |
| mem_addr_o | output | AW | Record memory read address |
| mem_rdata_i | input | 8 | Record memory read data |
| log_stop_o | output | 1 | Stop request to the logging process |
| power_off_o | output | 1 | Download finished, unit may power down |

## Verification
The delicate overlap is an acknowledge byte landing in the same cycle as the acknowledge timeout expiring. The bench counts cycles from the ID handshake edge and places the 0x06 byte exactly on the expiry edge. The scoreboard then expects the first data byte and no repeated ID. The bench also moves the acknowledge one cycle later. There the retry ID must appear and the late acknowledge must be dropped. Contention delay is judged by counting cycles from the final poll byte to the first valid ID.

// File: rtl/uldl_pkg.sv
package uldl_pkg;
  typedef enum logic [3:0] {
    ST_LISTEN, ST_PRIO, ST_SEND_ID, ST_WAIT_ACK, ST_STREAM,
    ST_CNT_HI, ST_CNT_LO, ST_WAIT_RES, ST_OFF
  } dl_state_e;

  localparam logic [7:0]  RSP_ACK   = 8'h06;
  localparam logic [7:0]  RSP_BAD   = 8'h15;
  localparam logic [7:0]  RSP_OK    = 8'h04;
  localparam logic [31:0] POLL_WORD = 32'h6672_6565;
  localparam int          PTS_W     = 16;
endpackage

// File: rtl/uldl_word_match.sv
module uldl_word_match #(
  parameter int                LEN  = 4,
  parameter logic [8*LEN-1:0]  WORD = 32'h6672_6565
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  output logic       hit_o
);
  localparam int HW = 8 * (LEN - 1);

  logic [HW-1:0]  hist_q;
  logic [LEN-1:0] eq;
  logic           hit_q;

  // eq[0]: incoming byte vs last char; eq[i+1]: i-th newest history byte
  assign eq[0] = (data_i == WORD[7:0]);
  for (genvar i = 0; i < LEN - 1; i++) begin : g_cmp
    assign eq[i+1] = (hist_q[8*i +: 8] == WORD[8*(i+1) +: 8]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      hit_q  <= 1'b0;
    end else if (!en_i) begin
      hist_q <= '0;
      hit_q  <= 1'b0;
    end else begin
      hit_q <= valid_i && (&eq);
      if (valid_i) hist_q <= (hist_q << 8) | HW'(data_i);
    end
  end

  assign hit_o = hit_q;

  AST_HIT_FROM_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(valid_i && en_i && data_i == WORD[7:0])); // R2
endmodule

// File: rtl/uldl_timer.sv
module uldl_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;
  logic         run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= val_i;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = run_q && (cnt_q == '0);

  AST_EXPIRE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o && !load_i |=> !expired_o); // R4
endmodule

// File: rtl/uplink_dl_ctrl.sv
module uplink_dl_ctrl
  import uldl_pkg::*;
#(
  parameter int AW        = 12,
  parameter int DLY_W     = 8,
  parameter int ACK_TO    = 1000,
  parameter int REC_BYTES = 43
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wake_i,
  input  logic [7:0]       unit_id_i,
  input  logic [DLY_W-1:0] prio_delay_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             tx_ready_i,
  output logic             tx_valid_o,
  output logic [7:0]       tx_data_o,
  input  logic [AW-1:0]    last_ptr_i,
  output logic [AW-1:0]    mem_addr_o,
  input  logic [7:0]       mem_rdata_i,
  output logic             log_stop_o,
  output logic             power_off_o
);
  localparam int ACK_W = $clog2(ACK_TO + 1);
  localparam int TMR_W = (ACK_W > DLY_W) ? ACK_W : DLY_W;
  localparam int REC_W = $clog2(REC_BYTES + 1);

  dl_state_e        state_q;
  logic [AW-1:0]    addr_q;
  logic [REC_W-1:0] rec_q;
  logic [PTS_W-1:0] pts_q;
  logic             retry_q;
  logic             stop_q;

  logic             poll_hit, tmr_load, tmr_exp, fire;
  logic [TMR_W-1:0] tmr_val;
  logic             rx_ack, rx_bad, rx_ok;

  uldl_word_match #(.LEN(4), .WORD(POLL_WORD)) i_match (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_LISTEN),
    .valid_i(rx_valid_i),
    .data_i (rx_data_i),
    .hit_o  (poll_hit)
  );

  uldl_timer #(.W(TMR_W)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .val_i    (tmr_val),
    .expired_o(tmr_exp)
  );

  assign rx_ack = rx_valid_i && (rx_data_i == RSP_ACK);
  assign rx_bad = rx_valid_i && (rx_data_i == RSP_BAD);
  assign rx_ok  = rx_valid_i && (rx_data_i == RSP_OK);

  always_comb begin
    tx_valid_o = 1'b0;
    tx_data_o  = 8'h00;
    unique case (state_q)
      ST_SEND_ID: begin tx_valid_o = 1'b1; tx_data_o = unit_id_i;   end
      ST_STREAM:  begin tx_valid_o = 1'b1; tx_data_o = mem_rdata_i; end
      ST_CNT_HI:  begin tx_valid_o = 1'b1; tx_data_o = pts_q[15:8]; end
      ST_CNT_LO:  begin tx_valid_o = 1'b1; tx_data_o = pts_q[7:0];  end
      default:    ;
    endcase
  end

  assign fire = tx_valid_o && tx_ready_i;

  // one timer serves both the contention delay and the ack window
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TMR_W'(prio_delay_i);
    if (state_q == ST_LISTEN && poll_hit) begin
      tmr_load = 1'b1;
    end else if (state_q == ST_SEND_ID && fire) begin
      tmr_load = 1'b1;
      tmr_val  = TMR_W'(ACK_TO);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LISTEN;
      addr_q  <= '0;
      rec_q   <= '0;
      pts_q   <= '0;
      retry_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_LISTEN: if (poll_hit) begin
          state_q <= ST_PRIO;
          retry_q <= 1'b0;
        end
        ST_PRIO: if (tmr_exp) state_q <= ST_SEND_ID;
        ST_SEND_ID: if (fire) state_q <= ST_WAIT_ACK;
        ST_WAIT_ACK: begin
          if (rx_ack) begin          // ack wins over a same-cycle expiry
            state_q <= ST_STREAM;
            stop_q  <= 1'b1;
            addr_q  <= '0;
            rec_q   <= '0;
            pts_q   <= '0;
          end else if (tmr_exp) begin
            if (retry_q) state_q <= ST_LISTEN;
            else begin
              state_q <= ST_SEND_ID;
              retry_q <= 1'b1;
            end
          end
        end
        ST_STREAM: if (fire) begin
          if (rec_q == REC_W'(REC_BYTES - 1)) begin
            rec_q <= '0;
            pts_q <= pts_q + 1'b1;
          end else begin
            rec_q <= rec_q + 1'b1;
          end
          if (addr_q == last_ptr_i) state_q <= ST_CNT_HI;
          else                      addr_q  <= addr_q + 1'b1;
        end
        ST_CNT_HI: if (fire) state_q <= ST_CNT_LO;
        ST_CNT_LO: if (fire) state_q <= ST_WAIT_RES;
        ST_WAIT_RES: begin
          if (rx_bad) begin
            state_q <= ST_STREAM;
            addr_q  <= '0;
            rec_q   <= '0;
            pts_q   <= '0;
          end else if (rx_ok) begin
            state_q <= ST_OFF;
          end
        end
        ST_OFF: if (wake_i) begin
          state_q <= ST_LISTEN;
          stop_q  <= 1'b0;
          addr_q  <= '0;
        end
        default: state_q <= ST_LISTEN;
      endcase
    end
  end

  assign mem_addr_o  = addr_q;
  assign log_stop_o  = stop_q;
  assign power_off_o = (state_q == ST_OFF);

  AST_STREAM_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STREAM) |-> log_stop_o); // R6
  AST_HOLD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(mem_addr_o)); // R7
  AST_HOLD_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i && state_q != ST_STREAM |=> $stable(tx_data_o)); // R7
  AST_ADDR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STREAM) |-> mem_addr_o <= last_ptr_i); // R7
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    power_off_o |-> !tx_valid_o); // R10
  AST_ID_AFTER_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_SEND_ID) |-> $past(tmr_exp)); // R3
endmodule

// File: tb/test_uplink_dl_ctrl.sv
`timescale 1ns/1ps
module test_uplink_dl_ctrl;
  localparam int AW = 12, DLY_W = 8, ACK_TO = 20, REC_BYTES = 4;
  localparam logic [7:0] UID = 8'hA5;
  localparam int LAST = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wake = 1'b0;
  logic [DLY_W-1:0] prio = 8'd5;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic tx_ready = 1'b1;
  logic ready_mode = 1'b1;
  logic tx_valid, log_stop, power_off;
  logic [7:0] tx_data, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [AW-1:0] last_ptr = AW'(LAST);

  int errors = 0, checks = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  always_comb mem_rdata = 8'(mem_addr * 7 + 3);

  uplink_dl_ctrl #(.AW(AW), .DLY_W(DLY_W), .ACK_TO(ACK_TO), .REC_BYTES(REC_BYTES)) i_uplink_dl_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wake_i(wake), .unit_id_i(UID), .prio_delay_i(prio),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .tx_ready_i(tx_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .last_ptr_i(last_ptr),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .log_stop_o(log_stop), .power_off_o(power_off));

  always @(posedge clk) begin
    #1;
    tx_ready = ready_mode ? 1'b1 : ~tx_ready;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  task automatic push_download();
    for (int i = 0; i <= LAST; i++) push(8'(i * 7 + 3), "R7 data byte");
    push(8'h00, "R8 count high");
    push(8'(( LAST + 1) / REC_BYTES), "R8 count low");
  endtask

  // monitor: pop and compare on every handshake
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2/R10 unexpected byte actual=%0h expected=none", tx_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {24'h0, tx_data}, {24'h0, e});
      end
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_poll_prefix();
    send_byte(8'h66); send_byte(8'h72); send_byte(8'h65);
  endtask

  // sends final 'e' and counts negedges until the ID is valid
  task automatic last_e_and_time(input int dly);
    int n;
    send_byte(8'h65);
    n = 1;
    while (!tx_valid && n < 1000) begin @(negedge clk); n++; end
    chk("R3 contention delay", n, dly + 3);
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 5000) begin @(negedge clk); guard++; end
    chk("R7 scoreboard drained", exp_q.size(), 0);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 log_stop", log_stop, 0);
    chk("R1 power_off", power_off, 0);
    chk("R1 mem_addr", mem_addr, 0);

    // R2: near-miss sequences do nothing
    send_poll_prefix(); send_byte(8'h78);
    send_poll_prefix(); send_byte(8'h64);
    repeat (12) @(negedge clk);
    chk("R2 no trigger on near miss", tx_valid, 0);

    // R2/R3/R4: "ffree", no ack at all -> ID twice then listen
    push(UID, "R3 first ID"); push(UID, "R4 retry ID");
    send_byte(8'h66);
    send_poll_prefix();
    last_e_and_time(5);
    repeat (5) @(negedge clk);
    send_byte(8'h41); // R5 non-ack byte ignored
    repeat (3 * ACK_TO) @(negedge clk);
    chk("R4 back to listen, idle tx", tx_valid, 0);
    chk("R4 logger not stopped", log_stop, 0);
    chk("R4 exactly two IDs", exp_q.size(), 0);

    // R5: ack on the expiry edge wins
    prio = 8'd0;
    push(UID, "R5 single ID");
    push_download();
    send_poll_prefix();
    last_e_and_time(0);
    repeat (ACK_TO) @(negedge clk);
    send_byte(8'h06);
    chk("R6 log_stop after ack", log_stop, 1);
    ready_mode = 1'b0;
    drain();
    chk("R6 log_stop held", log_stop, 1);

    // R9: mismatch replays everything
    push_download();
    send_byte(8'h15);
    drain();

    // R10: success then ignore polls until wake
    ready_mode = 1'b1;
    send_byte(8'h04);
    chk("R10 power_off", power_off, 1);
    chk("R10 tx idle", tx_valid, 0);
    send_poll_prefix(); send_byte(8'h65);
    repeat (20) @(negedge clk);
    chk("R10 poll ignored while off", tx_valid, 0);
    chk("R10 still off", power_off, 1);
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
    chk("R10 wake clears power_off", power_off, 0);
    chk("R10 wake clears log_stop", log_stop, 0);

    // R5: ack one cycle late lands on retry, is dropped
    prio = 8'd3;
    push(UID, "R5 ID"); push(UID, "R5 retry after late ack");
    send_poll_prefix();
    last_e_and_time(3);
    repeat (ACK_TO + 1) @(negedge clk);
    send_byte(8'h06);
    drain();
    chk("R5 late ack not taken", log_stop, 0);
    push_download();
    send_byte(8'h06);
    drain();
    send_byte(8'h04);
    chk("R10 final power_off", power_off, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule